// File: doc/BRIEF.md
# Single-Step Trace Exception Controller

This block sits beside a processor core and decides when the core must take a single-step (trace) exception. It owns the status bits that govern tracing: the global interrupt mask bit, the user bit, the trace enable bit and the interrupt priority mask field. It also holds the active interrupt control mode. After each retired instruction it checks whether tracing is armed and, if so, raises a trace request that stays up until the core confirms it has entered the exception.

When the core acknowledges trace entry, the block updates the status bits. The trace enable bit clears, so the handler is not itself traced. The interrupt mask bit is set, and the other fields keep their values. When a return-from-exception retires, the block reloads the whole status from the copy the core popped from its stack. Because that copy still holds trace enable = 1, tracing resumes with the next instruction. The return instruction itself never raises a trace.

Interrupts from the priority controller pass through the block to the core one cycle later. They are held back in any cycle where a trace request is pending, so the trace entry is always taken first.

Top module: `trace_step_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the outputs are as follows: trace request 0, forwarded interrupt 0, trace enable 0, interrupt mask bit 1, user bit 0, priority mask all ones. The interrupt control mode is 0.
- R2: When an instruction retires that is not a return-from-exception, while trace enable is 1 and the mode equals TRACE_MODE (default 2), the trace request is 1 in the following cycle.
- R3: In any mode other than TRACE_MODE, a retire raises no trace request, whatever the trace enable bit holds.
- R4: The trace request does not depend on the interrupt mask bit, the user bit or the priority mask field.
- R5: A retire flagged as return-from-exception raises no trace request, even when trace enable is 1.
- R6: An acknowledge while the request is 1 has these effects in the next cycle: the request drops to 0, trace enable is 0, the interrupt mask bit is 1, and the user bit and priority mask keep their values.
- R7: A return-from-exception retire loads every status field from the saved-status port, visible in the next cycle. If the loaded trace enable is 1 and the mode is TRACE_MODE, the next ordinary retire raises a request.
- R8: Once raised, the request stays at 1 until it is acknowledged, whatever further retires occur. After the acknowledge, trace enable is 0, so retires inside the handler raise no request.
- R9: The forwarded interrupt equals the interrupt input of the previous cycle. It is forced to 0 in every cycle where the trace request is 1.
- R10: Status updates follow a fixed priority: trace acknowledge first, then return-from-exception load, then the status write port. The status write and saved-status ports use the same 6-bit layout, with the interrupt mask bit at bit 5, the user bit at bit 4, trace enable at bit 3 and the priority mask in bits 2:0. The mode write port loads the mode in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retires this cycle |
| rte_i | input | 1 | The retiring instruction is a return-from-exception |
| mode_we_i | input | 1 | Write strobe for the interrupt control mode |
| mode_d_i | input | MODE_W | New interrupt control mode |
| sr_we_i | input | 1 | Write strobe for the status bits |
| sr_d_i | input | MASK_W+3 | New status value (layout in R10) |
| saved_sr_i | input | MASK_W+3 | Status popped by return-from-exception (layout in R10) |
| ack_i | input | 1 | Core has entered the trace exception |
| irq_i | input | 1 | Interrupt pending from the priority controller |
| trace_req_o | output | 1 | Trace exception request |
| irq_fwd_o | output | 1 | Interrupt presented to the core |
| ccr_i_o | output | 1 | Interrupt mask bit |
| ccr_ui_o | output | 1 | User bit |
| exr_t_o | output | 1 | Trace enable bit |
| exr_imask_o | output | MASK_W | Interrupt priority mask |

## Verification
The bench uses the default parameters: a two-bit mode, TRACE_MODE = 2 and a three-bit priority mask. With these values every mode value can be tried, including mode 1 and mode 3, which are never written in normal use. A three-bit mask with mixed bit values shows whether a trace entry preserves each bit. Directed sequences cover the following: the handler entry and return round trip, a request held across several retires, and priority collisions between acknowledge, return and status write. A random phase then drives every port with collisions allowed.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  parameter int unsigned MASK_W = 3;
  localparam int unsigned SR_W = MASK_W + 3;

  typedef struct packed {
    logic              i;
    logic              ui;
    logic              t;
    logic [MASK_W-1:0] imask;
  } tsc_status_t;
endpackage

// File: rtl/tsc_mode_reg.sv
module tsc_mode_reg #(
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MODE_W-1:0] d,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst)     mode_q <= '0;
    else if (we) mode_q <= d;
  end
endmodule

// File: rtl/tsc_status.sv
module tsc_status
  import tsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take_trace,
  input  logic        rte_load,
  input  logic        sr_we,
  input  tsc_status_t saved,
  input  tsc_status_t sr_d,
  output tsc_status_t st_q
);
  tsc_status_t st_d;

  always_comb begin
    st_d = st_q;
    if (take_trace) begin
      st_d.i = 1'b1;
      st_d.t = 1'b0;
    end else if (rte_load) begin
      st_d = saved;
    end else if (sr_we) begin
      st_d = sr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q.i     <= 1'b1;
      st_q.ui    <= 1'b0;
      st_q.t     <= 1'b0;
      st_q.imask <= '1;
    end else begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/tsc_trace_seq.sv
module tsc_trace_seq #(
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned TRACE_MODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire,
  input  logic              rte,
  input  logic              t_bit,
  input  logic [MODE_W-1:0] mode,
  input  logic              ack,
  input  logic              irq_in,
  output logic              req_q,
  output logic              irq_q,
  output logic              take_trace
);
  localparam logic [MODE_W-1:0] TRACE_SEL = MODE_W'(TRACE_MODE);

  logic armed;
  logic req_d;

  assign armed      = t_bit && (mode == TRACE_SEL);
  assign take_trace = req_q && ack;

  always_comb begin
    req_d = req_q;
    if (take_trace)                     req_d = 1'b0;
    else if (retire && !rte && armed)   req_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      req_q <= req_d;
      irq_q <= irq_in && !req_d;
    end
  end
endmodule

// File: rtl/trace_step_ctrl.sv
module trace_step_ctrl
  import tsc_pkg::*;
#(
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned TRACE_MODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_i,
  input  logic              rte_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_d_i,
  input  logic              sr_we_i,
  input  logic [SR_W-1:0]   sr_d_i,
  input  logic [SR_W-1:0]   saved_sr_i,
  input  logic              ack_i,
  input  logic              irq_i,
  output logic              trace_req_o,
  output logic              irq_fwd_o,
  output logic              ccr_i_o,
  output logic              ccr_ui_o,
  output logic              exr_t_o,
  output logic [MASK_W-1:0] exr_imask_o
);
  logic [MODE_W-1:0] mode_q;
  tsc_status_t       st_q;
  logic              take_trace;

  tsc_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst(rst), .we(mode_we_i), .d(mode_d_i), .mode_q(mode_q)
  );

  tsc_trace_seq #(.MODE_W(MODE_W), .TRACE_MODE(TRACE_MODE)) u_seq (
    .clk(clk), .rst(rst), .retire(retire_i), .rte(rte_i), .t_bit(st_q.t),
    .mode(mode_q), .ack(ack_i), .irq_in(irq_i), .req_q(trace_req_o),
    .irq_q(irq_fwd_o), .take_trace(take_trace)
  );

  tsc_status u_st (
    .clk(clk), .rst(rst), .take_trace(take_trace),
    .rte_load(retire_i && rte_i), .sr_we(sr_we_i),
    .saved(tsc_status_t'(saved_sr_i)), .sr_d(tsc_status_t'(sr_d_i)),
    .st_q(st_q)
  );

  assign ccr_i_o     = st_q.i;
  assign ccr_ui_o    = st_q.ui;
  assign exr_t_o     = st_q.t;
  assign exr_imask_o = st_q.imask;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
#(
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned TRACE_MODE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              retire_i,
  input logic              rte_i,
  input logic              ack_i,
  input logic [MODE_W-1:0] mode_q,
  input logic [SR_W-1:0]   saved_sr_i,
  input logic              trace_req_o,
  input logic              irq_fwd_o,
  input logic              ccr_i_o,
  input logic              ccr_ui_o,
  input logic              exr_t_o,
  input logic [MASK_W-1:0] exr_imask_o
);
  logic [SR_W-1:0] st_vec;
  assign st_vec = {ccr_i_o, ccr_ui_o, exr_t_o, exr_imask_o};

  AST_REQ_FROM_RETIRE: assert property (@(posedge clk) disable iff (rst)
    $rose(trace_req_o) |-> $past(retire_i && !rte_i && exr_t_o)); // R2
  AST_REQ_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(trace_req_o) |-> $past(mode_q) == MODE_W'(TRACE_MODE)); // R3
  AST_RTE_NO_TRACE: assert property (@(posedge clk) disable iff (rst)
    (retire_i && rte_i && !trace_req_o) |=> !trace_req_o); // R5
  AST_ACK_STATUS: assert property (@(posedge clk) disable iff (rst)
    (trace_req_o && ack_i) |=> (!trace_req_o && ccr_i_o && !exr_t_o
      && $stable(ccr_ui_o) && $stable(exr_imask_o))); // R6
  AST_RTE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (retire_i && rte_i && !(trace_req_o && ack_i)) |=> st_vec == $past(saved_sr_i)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (trace_req_o && !ack_i) |=> trace_req_o); // R8
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    irq_fwd_o |-> !trace_req_o); // R9
endmodule

bind trace_step_ctrl tsc_checker u_chk (
  .clk(clk), .rst(rst), .retire_i(retire_i), .rte_i(rte_i), .ack_i(ack_i),
  .mode_q(mode_q), .saved_sr_i(saved_sr_i), .trace_req_o(trace_req_o),
  .irq_fwd_o(irq_fwd_o), .ccr_i_o(ccr_i_o), .ccr_ui_o(ccr_ui_o),
  .exr_t_o(exr_t_o), .exr_imask_o(exr_imask_o)
);

// File: tb/sim_trace_step_ctrl.sv
`timescale 1ns/1ps
module sim_trace_step_ctrl;
  import tsc_pkg::*;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned TMODE  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retire = 0, rte = 0, mode_we = 0, sr_we = 0, ack = 0, irq = 0;
  logic [MODE_W-1:0] mode_d = '0;
  logic [SR_W-1:0]   sr_d = '0, saved = '0;
  logic trace_req, irq_fwd, c_i, c_ui, e_t;
  logic [MASK_W-1:0] e_mask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trace_step_ctrl u0 (
    .clk(clk), .rst(rst), .retire_i(retire), .rte_i(rte), .mode_we_i(mode_we),
    .mode_d_i(mode_d), .sr_we_i(sr_we), .sr_d_i(sr_d), .saved_sr_i(saved),
    .ack_i(ack), .irq_i(irq), .trace_req_o(trace_req), .irq_fwd_o(irq_fwd),
    .ccr_i_o(c_i), .ccr_ui_o(c_ui), .exr_t_o(e_t), .exr_imask_o(e_mask)
  );

  // behavioural reference model
  int m_mode, m_i, m_ui, m_t, m_mask, m_req, m_irq, n_req;
  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_i = 1; m_ui = 0; m_t = 0; m_mask = 7; m_req = 0; m_irq = 0;
    end else begin
      n_req = m_req;
      if (m_req == 1 && ack) n_req = 0;
      else if (m_req == 0 && retire && !rte && m_t == 1 && m_mode == TMODE) n_req = 1;
      if (m_req == 1 && ack) begin m_i = 1; m_t = 0; end
      else if (retire && rte) begin
        m_i = saved[5]; m_ui = saved[4]; m_t = saved[3]; m_mask = int'(saved[2:0]);
      end else if (sr_we) begin
        m_i = sr_d[5]; m_ui = sr_d[4]; m_t = sr_d[3]; m_mask = int'(sr_d[2:0]);
      end
      if (mode_we) m_mode = int'(mode_d);
      m_irq = (irq && n_req == 0) ? 1 : 0;
      m_req = n_req;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    total++;
    if (int'(trace_req) != m_req || int'(irq_fwd) != m_irq || int'(c_i) != m_i ||
        int'(c_ui) != m_ui || int'(e_t) != m_t || int'(e_mask) != m_mask) begin
      bad++;
      $display("FAIL %s actual req=%0d irq=%0d i=%0d ui=%0d t=%0d mask=%0d expected req=%0d irq=%0d i=%0d ui=%0d t=%0d mask=%0d",
               tag, trace_req, irq_fwd, c_i, c_ui, e_t, e_mask,
               m_req, m_irq, m_i, m_ui, m_t, m_mask);
    end
  endtask

  task automatic cyc(input logic r, input logic x, input logic a, input logic q, input string tag);
    retire = r; rte = x; ack = a; irq = q;
    @(posedge clk); #2;
    compare(tag);
    retire = 0; rte = 0; ack = 0; irq = 0; sr_we = 0; mode_we = 0;
  endtask

  task automatic wr_mode(input int m);
    mode_we = 1; mode_d = MODE_W'(m);
    cyc(0, 0, 0, 0, "R10");
  endtask

  task automatic wr_sr(input logic [SR_W-1:0] v);
    sr_we = 1; sr_d = v;
    cyc(0, 0, 0, 0, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 req in reset", int'(trace_req), 0);
    rst = 0;
    cyc(0, 0, 0, 0, "R1");
    chk("R1 t", int'(e_t), 0);
    chk("R1 i", int'(c_i), 1);
    chk("R1 ui", int'(c_ui), 0);
    chk("R1 mask", int'(e_mask), 7);
    chk("R1 irq", int'(irq_fwd), 0);

    wr_mode(TMODE);
    wr_sr(6'b1_1_1_101);
    cyc(1, 0, 0, 0, "R2");
    chk("R2 req after retire", int'(trace_req), 1);
    chk("R4 req with masks set", int'(trace_req), 1);
    cyc(1, 0, 0, 1, "R8");
    chk("R8 req held", int'(trace_req), 1);
    chk("R9 irq held", int'(irq_fwd), 0);
    cyc(0, 0, 1, 0, "R6");
    chk("R6 req drop", int'(trace_req), 0);
    chk("R6 t cleared", int'(e_t), 0);
    chk("R6 i set", int'(c_i), 1);
    chk("R6 ui kept", int'(c_ui), 1);
    chk("R6 mask kept", int'(e_mask), 5);
    cyc(1, 0, 0, 1, "R8");
    chk("R8 handler untraced", int'(trace_req), 0);
    chk("R9 irq passes", int'(irq_fwd), 1);

    saved = 6'b0_1_1_010;
    cyc(1, 1, 0, 0, "R5");
    chk("R5 rte no trace", int'(trace_req), 0);
    chk("R7 loaded", int'({c_i, c_ui, e_t, e_mask}), int'(6'b0_1_1_010));
    cyc(1, 0, 0, 0, "R7");
    chk("R7 rearmed", int'(trace_req), 1);
    chk("R4 req with i clear", int'(trace_req), 1);
    cyc(0, 0, 1, 0, "R6");

    saved = 6'b1_0_1_001;
    sr_we = 1; sr_d = '0;
    cyc(1, 1, 0, 0, "R10");
    chk("R10 rte over write", int'({c_i, c_ui, e_t, e_mask}), int'(6'b1_0_1_001));
    cyc(1, 0, 0, 0, "R2");
    chk("R2 req", int'(trace_req), 1);
    saved = 6'b0_0_1_110;
    cyc(1, 1, 1, 0, "R10");
    chk("R10 ack over rte t", int'(e_t), 0);
    chk("R10 ack over rte mask", int'(e_mask), 1);

    wr_mode(0);
    wr_sr(6'b0_0_1_000);
    cyc(1, 0, 0, 0, "R3");
    chk("R3 mode0 no trace", int'(trace_req), 0);
    wr_mode(1);
    cyc(1, 0, 0, 0, "R3");
    chk("R3 mode1 no trace", int'(trace_req), 0);
    wr_mode(3);
    cyc(1, 0, 0, 0, "R3");
    chk("R3 mode3 no trace", int'(trace_req), 0);

    for (int k = 0; k < 600; k++) begin
      mode_we = ($urandom % 16) == 0;
      mode_d  = (($urandom % 4) == 0) ? MODE_W'($urandom) : MODE_W'(TMODE);
      sr_we   = ($urandom % 6) == 0;
      sr_d    = SR_W'($urandom);
      saved   = SR_W'($urandom);
      cyc(($urandom % 2) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
          ($urandom % 2) == 0, "RND R2 R9 R10");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule